// File: doc/BRIEF.md
# Flash Program/Erase Control Register Block

This block holds the software-visible control state that steps an on-chip flash array through program and erase operations. A processor reaches it over a small register bus: an address, a write strobe, write data and combinational read data. It holds two registers. The control register has a master write enable, a setup bit for each of program and erase, a go bit for each, and a verify bit for each. The block-select register is an 8-bit mask that names the one flash block an erase may touch.

The block guards this state in hardware. Control bits can only be raised while the master enable is already up, and no more than one bit may rise per write. A go bit needs its own setup bit in place first. The program and erase sides exclude each other. Dropping the master enable wipes all dependent state, including the block mask. Reset and both standby inputs clear everything. A register-access enable gates the bus. A flash-present flag hides the block mask. One operating mode locks the top mask bit.

Three registered outputs go toward the array: erase active, program active and the block mask. Each reflects the register state from the clock edge that wrote it.

Top module: `flash_pe_regs`

## Requirements
- R1: Asynchronous reset (rstN low), and a synchronous hwStandby or swStandby high at a clock edge, clear the control register and the block mask to zero.
- R2: Address 0 is the control register. Its bits are: bit0 write enable, bit1 program setup, bit2 erase setup, bit3 program go, bit4 erase go, bit5 program verify, bit6 erase verify. Bit7 reads 0. Address 1 is the block mask. Writing 0 to write enable clears every control bit and the block mask at the same edge.
- R3: The two setup bits and the two verify bits can be raised only while write enable is already 1. A write that tries to raise one of them while write enable is 0 leaves it at 0.
- R4: Only one control bit may go from 0 to 1 in a single write. If a write would raise two or more bits, none of them rises. Bits written 0 are still cleared.
- R5: Program go rises only if program setup is already 1. Erase go rises only if erase setup is already 1. Clearing a setup bit also clears its go bit.
- R6: A setup bit cannot be raised while the other side's setup bit or go bit is 1.
- R7: The block mask is 0 whenever write enable is 0. Writes to the mask take effect only while write enable is 1.
- R8: At most one block mask bit is 1 at any time. A mask write with two or more bits set is rejected, and the previous mask is kept. A write of zero is accepted.
- R9: While flashPresent is 0, reads of address 1 return 0 and writes to address 1 are discarded.
- R10: While opMode equals 2, the written value of mask bit 7 is ignored and bit 7 keeps its previous value. The remaining bits are written as usual, subject to R8.
- R11: While regAccessEn is 0, writes to both registers are ignored and busRdata is 0.
- R12: programActive, eraseActive and blockMask equal the program go bit, the erase go bit and the mask register from the clock edge that wrote them onward. busRdata shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwStandby | input | 1 | Hardware standby, clears all state |
| swStandby | input | 1 | Software standby, clears all state |
| opMode | input | 2 | Operating mode; value 2 locks mask bit 7 |
| regAccessEn | input | 1 | Register bus access enable |
| flashPresent | input | 1 | On-chip flash enabled |
| busAddr | input | 1 | Register address (0 control, 1 block mask) |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data |
| eraseActive | output | 1 | Erase go bit toward the array |
| programActive | output | 1 | Program go bit toward the array |
| blockMask | output | 8 | Selected erase block mask |

## Verification
Directed sequences walk through a full program setup and go, and a full erase setup, mask and go. On the way they try each illegal move once. These include a setup bit raised without the enable, two bits raised in one write, a go bit without its setup, and a cross-side setup. Further cases cover a multi-bit mask, a bit-7 write in mode 2, a hidden flash and a closed bus. Each of these is told apart from the legal move that sits next to it.

Random writes are seeded and biased toward raising a single bit on top of the current state, so long legal chains form. Mixed with them are arbitrary data, random modes and occasional standby. These runs catch combinations the directed cases miss, such as a setup cleared while its go bit is held.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int CTRL_BITS = 7;

  typedef struct packed {
    logic eraseVerify;
    logic progVerify;
    logic eraseGo;
    logic progGo;
    logic eraseSetup;
    logic progSetup;
    logic wrEnable;
  } ctrlBits_t;

  typedef struct packed {
    logic clearAll;
    logic wrCtrl;
    logic wrBlk;
    logic rdCtrl;
    logic rdBlk;
  } strobes_t;
endpackage

// File: rtl/fpe_bus_ctrl.sv
module fpe_bus_ctrl
  import fpe_pkg::*;
#(
  parameter int ADDR_W    = 1,
  parameter int CTRL_ADDR = 0,
  parameter int BLK_ADDR  = 1
) (
  input  logic              regAccessEn,
  input  logic              flashPresent,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output strobes_t          strb
);
  localparam logic [ADDR_W-1:0] CtrlSel = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] BlkSel  = ADDR_W'(BLK_ADDR);

  logic hitCtrl;
  logic hitBlk;

  always_comb begin
    hitCtrl       = regAccessEn && (busAddr == CtrlSel);
    hitBlk        = regAccessEn && (busAddr == BlkSel) && flashPresent;
    strb.clearAll = hwStandby || swStandby;
    strb.wrCtrl   = hitCtrl && busWrite && !strb.clearAll;
    strb.wrBlk    = hitBlk && busWrite && !strb.clearAll;
    strb.rdCtrl   = hitCtrl;
    strb.rdBlk    = hitBlk;
  end
endmodule

// File: rtl/fpe_datapath.sv
module fpe_datapath
  import fpe_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLK_W     = 8,
  parameter int MODE_W    = 2,
  parameter int LOCK_MODE = 2,
  parameter int LOCK_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MODE_W-1:0] opMode,
  output ctrlBits_t         ctrlQ,
  output logic [BLK_W-1:0]  blkQ,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_CTRL = DATA_W - CTRL_BITS;
  localparam int PAD_BLK  = DATA_W - BLK_W;
  localparam logic [MODE_W-1:0] LockSel = MODE_W'(LOCK_MODE);

  ctrlBits_t ctrlD;
  ctrlBits_t wrBits;
  ctrlBits_t allowBits;
  logic [CTRL_BITS-1:0] risingV;
  logic [CTRL_BITS-1:0] setV;
  logic [CTRL_BITS-1:0] candV;
  logic singleRise;
  logic [BLK_W-1:0] blkMerged;
  logic [BLK_W-1:0] blkD;
  logic blkOk;
  logic modeLocked;

  // control register next state
  always_comb begin
    wrBits     = ctrlBits_t'(wdata[CTRL_BITS-1:0]);
    risingV    = wrBits & ~ctrlQ;
    singleRise = ($countones(risingV) <= 1);

    allowBits             = '0;
    allowBits.wrEnable    = 1'b1;
    allowBits.progSetup   = ctrlQ.wrEnable && !ctrlQ.eraseSetup && !ctrlQ.eraseGo;
    allowBits.eraseSetup  = ctrlQ.wrEnable && !ctrlQ.progSetup && !ctrlQ.progGo;
    allowBits.progGo      = ctrlQ.progSetup;
    allowBits.eraseGo     = ctrlQ.eraseSetup;
    allowBits.progVerify  = ctrlQ.wrEnable;
    allowBits.eraseVerify = ctrlQ.wrEnable;

    setV  = risingV & allowBits & {CTRL_BITS{singleRise}};
    candV = (ctrlQ & wrBits) | setV;

    ctrlD = strb.wrCtrl ? ctrlBits_t'(candV) : ctrlQ;
    if (!ctrlD.progSetup)  ctrlD.progGo  = 1'b0;
    if (!ctrlD.eraseSetup) ctrlD.eraseGo = 1'b0;
    if (!ctrlD.wrEnable || strb.clearAll) ctrlD = '0;
  end

  // mask merge: one lane per bit, the lock lane picks the old value in lock mode
  always_comb modeLocked = (opMode == LockSel);

  for (genvar i = 0; i < BLK_W; i++) begin : g_lane
    if (i == LOCK_BIT) begin : g_lock
      always_comb blkMerged[i] = modeLocked ? blkQ[i] : wdata[i];
    end else begin : g_free
      always_comb blkMerged[i] = wdata[i];
    end
  end

  always_comb begin
    blkOk = strb.wrBlk && ctrlQ.wrEnable && ($countones(blkMerged) <= 1);
    blkD  = blkOk ? blkMerged : blkQ;
    if (!ctrlD.wrEnable || strb.clearAll) blkD = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      blkQ  <= '0;
    end else begin
      ctrlQ <= ctrlD;
      blkQ  <= blkD;
    end
  end

  always_comb begin
    rdata = '0;
    if (strb.rdCtrl)     rdata = {{PAD_CTRL{1'b0}}, ctrlQ};
    else if (strb.rdBlk) rdata = {{PAD_BLK{1'b0}}, blkQ};
  end
endmodule

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
  import fpe_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 1,
  parameter int CTRL_ADDR = 0,
  parameter int BLK_ADDR  = 1,
  parameter int BLK_W     = 8,
  parameter int MODE_W    = 2,
  parameter int LOCK_MODE = 2,
  parameter int LOCK_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [MODE_W-1:0] opMode,
  input  logic              regAccessEn,
  input  logic              flashPresent,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              eraseActive,
  output logic              programActive,
  output logic [BLK_W-1:0]  blockMask
);
  strobes_t  strb;
  ctrlBits_t ctrlQ;
  logic [CTRL_BITS-1:0] ctrlVec;

  fpe_bus_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .BLK_ADDR(BLK_ADDR)
  ) u_ctrl (
    .regAccessEn(regAccessEn), .flashPresent(flashPresent),
    .hwStandby(hwStandby), .swStandby(swStandby),
    .busAddr(busAddr), .busWrite(busWrite), .strb(strb)
  );

  fpe_datapath #(
    .DATA_W(DATA_W), .BLK_W(BLK_W), .MODE_W(MODE_W),
    .LOCK_MODE(LOCK_MODE), .LOCK_BIT(LOCK_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .opMode(opMode),
    .ctrlQ(ctrlQ), .blkQ(blockMask), .rdata(busRdata)
  );

  assign ctrlVec       = ctrlQ;
  assign eraseActive   = ctrlQ.eraseGo;
  assign programActive = ctrlQ.progGo;
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int BLK_W     = 8,
  parameter int MODE_W    = 2,
  parameter int LOCK_MODE = 2,
  parameter int LOCK_BIT  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              hwStandby,
  input logic              swStandby,
  input logic [MODE_W-1:0] opMode,
  input logic [6:0]        ctrlBits,
  input logic [BLK_W-1:0]  blockMask
);
  // R1
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwStandby || swStandby) |=> (ctrlBits == '0 && blockMask == '0));

  // R3
  prog_setup_needs_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBits[1]) |-> $past(ctrlBits[0]));

  // R3
  erase_setup_needs_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBits[2]) |-> $past(ctrlBits[0]));

  // R4
  single_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> ($countones(ctrlBits & ~$past(ctrlBits)) <= 1));

  // R5
  erase_go_needs_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBits[4]) |-> $past(ctrlBits[2]));

  // R5
  prog_go_needs_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBits[3]) |-> $past(ctrlBits[1]));

  // R7
  mask_needs_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[0] |-> (blockMask == '0));

  // R8
  mask_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blockMask));

  // R10
  lock_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opMode) == MODE_W'(LOCK_MODE)) |-> !$rose(blockMask[LOCK_BIT]));
endmodule

bind flash_pe_regs fpe_checker #(
  .BLK_W(BLK_W), .MODE_W(MODE_W), .LOCK_MODE(LOCK_MODE), .LOCK_BIT(LOCK_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
  .opMode(opMode), .ctrlBits(ctrlVec), .blockMask(blockMask)
);

// File: tb/tb_flash_pe_regs.sv
`timescale 1ns/1ps
module tb_flash_pe_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwStandby = 1'b0, swStandby = 1'b0;
  logic [1:0] opMode = 2'd0;
  logic regAccessEn = 1'b0, flashPresent = 1'b1;
  logic busAddr = 1'b0, busWrite = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic eraseActive, programActive;
  logic [7:0] blockMask;

  int nChecks = 0, nFails = 0, cycles = 0;
  logic [6:0] mC = '0;
  logic [7:0] mB = '0;

  always #4 clk = ~clk;

  flash_pe_regs dut (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
    .opMode(opMode), .regAccessEn(regAccessEn), .flashPresent(flashPresent),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .busRdata(busRdata), .eraseActive(eraseActive),
    .programActive(programActive), .blockMask(blockMask)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // reference for a control write
  function automatic logic [6:0] refCtrl(logic [6:0] c, logic [7:0] w);
    logic [6:0] n, up;
    logic ok;
    if (!w[0]) return 7'h00;
    up = w[6:0] & ~c;
    n  = c & w[6:0];
    if ($countones(up) == 1) begin
      ok = 1'b0;
      case (up)
        7'h01: ok = 1'b1;
        7'h02: ok = c[0] && !c[2] && !c[4];
        7'h04: ok = c[0] && !c[1] && !c[3];
        7'h08: ok = c[1];
        7'h10: ok = c[2];
        7'h20, 7'h40: ok = c[0];
        default: ok = 1'b0;
      endcase
      if (ok) n = n | up;
    end
    if (!n[1]) n[3] = 1'b0;
    if (!n[2]) n[4] = 1'b0;
    if (!n[0]) n = 7'h00;
    return n;
  endfunction

  function automatic logic [7:0] refBlk(logic [7:0] b, logic [7:0] w, logic [1:0] m);
    logic [7:0] v = w;
    if (m == 2'd2) v[7] = b[7];
    return ($countones(v) <= 1) ? v : b;
  endfunction

  function automatic logic [7:0] refRead(logic acc, logic a, logic fp);
    if (!acc) return 8'h00;
    if (!a) return {1'b0, mC};
    return fp ? mB : 8'h00;
  endfunction

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic acc, input logic wr, input logic a, input logic [7:0] d,
                      input logic [1:0] m, input logic fp, input logic hs, input logic ss,
                      input string tag);
    logic [6:0] cOld;
    regAccessEn = acc; busWrite = wr; busAddr = a; busWdata = d;
    opMode = m; flashPresent = fp; hwStandby = hs; swStandby = ss;
    @(posedge clk);
    cOld = mC;
    if (hs || ss) begin
      mC = '0; mB = '0;
    end else begin
      if (acc && wr && !a) mC = refCtrl(mC, d);
      if (acc && wr && a && fp && cOld[0]) mB = refBlk(mB, d, m);
      if (!mC[0]) mB = '0;
    end
    @(negedge clk);
    check(tag, {eraseActive, programActive, blockMask, busRdata},
          {mC[4], mC[3], mB, refRead(acc, a, fp)});
  endtask

  task automatic wc(input logic [7:0] d, input string tag);
    step(1'b1, 1'b1, 1'b0, d, 2'd0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic wb(input logic [7:0] d, input logic [1:0] m, input logic fp, input string tag);
    step(1'b1, 1'b1, 1'b1, d, m, fp, 1'b0, 1'b0, tag);
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED1234);
    regAccessEn = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", {eraseActive, programActive, blockMask, busRdata}, 18'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 setup without enable ignored
    wc(8'h02, "R3");
    // R4 enable and setup together rejected
    wc(8'h03, "R4");
    wc(8'h01, "R2");
    wc(8'h03, "R3");
    wc(8'h0B, "R5");
    wc(8'h0F, "R6");
    wc(8'h09, "R5");
    wc(8'h01, "R12");
    wc(8'h05, "R3");
    wb(8'h10, 2'd0, 1'b1, "R12");
    wb(8'h30, 2'd0, 1'b1, "R8");
    wb(8'h80, 2'd2, 1'b1, "R10");
    wb(8'h84, 2'd2, 1'b1, "R10");
    wb(8'h40, 2'd0, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b1, 8'h01, 2'd0, 1'b1, 1'b0, 1'b0, "R11");
    wc(8'h15, "R5");
    wc(8'h75, "R4");
    step(1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, "R11");
    wc(8'h00, "R2");
    wb(8'h01, 2'd0, 1'b1, "R7");
    wc(8'h01, "R2");
    wb(8'h80, 2'd0, 1'b1, "R8");
    wc(8'h21, "R3");
    step(1'b1, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 1'b0, "R1");
    wc(8'h01, "R2");
    wb(8'h02, 2'd0, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b1, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, "R1");

    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      logic [7:0] d;
      logic a = ($urandom_range(0, 3) == 0);
      if (r < 55) d = {1'b0, mC} | (8'h01 << $urandom_range(0, 6));
      else if (r < 70) d = {1'b0, mC} & ~(8'h01 << $urandom_range(1, 6));
      else d = 8'($urandom);
      if (a && $urandom_range(0, 2) != 0) d = 8'h01 << $urandom_range(0, 7);
      step($urandom_range(0, 15) != 0, $urandom_range(0, 7) != 0, a, d,
           2'($urandom_range(0, 3)), $urandom_range(0, 9) != 0,
           $urandom_range(0, 60) == 0, $urandom_range(0, 60) == 0,
           a ? "R8" : "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule